// File: doc/BRIEF.md
# Colour Lookup Table Register Port

This block holds a 256-entry colour table. Each entry keeps an 8-bit red, an 8-bit green and an 8-bit blue value. Software loads the table through a 16-byte window of 32-bit registers. One register selects the entry to write. A second register accepts the colour bytes one at a time: red first, then green, then blue. After the blue byte the entry pointer moves to the next entry by itself, so a run of consecutive entries needs only one pointer write followed by a stream of colour bytes.

The payload byte of both registers sits in bits 31:24 of the bus word. A separate lookup port serves the pixel path. It takes an entry number and returns that entry's 24-bit colour one clock later. Bus reads of the window always return zero.

Top module: `clut_regport`

## Requirements
- R1: After reset every entry reads back as black (0x000000), except entry 255, which reads as white (0xFFFFFF). The entry pointer is 0 and the next colour write goes to red.
- R2: A full-word write at byte offset 0 sets the entry pointer to data bits 31:24. It also restarts the colour sequence, so the next colour write goes to red.
- R3: Full-word writes at byte offset 4 store data bits 31:24 into the current entry: the first into red, the second into green, the third into blue. Each byte is stored as soon as it is written.
- R4: After the blue write the entry pointer increments modulo 256, so entry 255 is followed by entry 0, and the sequence returns to red.
- R5: A pointer write in the middle of a colour sequence leaves the bytes already written in place. The next colour write then goes to red of the newly selected entry.
- R6: The lookup port is registered. The colour of the entry selected by `lkIdx` at a rising edge appears on `lkColor` after that edge. Red is in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R7: When a colour write and a lookup hit the same entry at the same edge, the lookup returns the value the entry held before the write.
- R8: A write with any of the four byte enables low changes nothing: not the table, not the pointer, not the sequence position.
- R9: Writes at byte offsets 8 and 12 are ignored, and so are writes whose address is not word aligned.
- R10: Bus read data is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the register window |
| wrAddr | input | 4 | Byte offset within the 16-byte window |
| wrData | input | 32 | Write data; the payload is in bits 31:24 |
| wrBe | input | 4 | Byte enables; all four must be high for a write to take effect |
| rdData | output | 32 | Bus read data, always zero |
| lkIdx | input | 8 | Entry selected for lookup |
| lkColor | output | 24 | Registered colour {red, green, blue} of the selected entry |

## Verification
The first pattern streams colour bytes without any pointer write. It shows whether reset leaves the pointer at entry 0 and the sequence at red. Runs that start at entries 10 and 255 each cover two consecutive entries. They separate a correct modulo-256 increment from a stuck pointer or one that does not wrap. An interrupted red-green sequence followed by a pointer reload tells "bytes stored at once" apart from "stored on completion", and also checks that the sequence restarts at red. Writes with partial byte enables, at unused offsets, and at unaligned addresses are each followed by a colour write whose landing place shows whether the pointer or the sequence moved. A lookup issued at the same edge as a write to the same entry separates read-before-write from write-through.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int unsigned IDX_W   = 8;
  localparam int unsigned COMP_W  = 8;
  localparam int unsigned NCOMP   = 3;
  localparam int unsigned ENTRIES = 1 << IDX_W;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned BE_W    = DATA_W / 8;
  localparam int unsigned COLOR_W = NCOMP * COMP_W;

  // Strobes from control to the table planes; compWe bit 0 = red.
  typedef struct packed {
    logic [NCOMP-1:0]  compWe;
    logic [IDX_W-1:0]  entry;
    logic [COMP_W-1:0] value;
  } clutStrobe_t;
endpackage

// File: rtl/clut_ctrl.sv
module clut_ctrl
  import clut_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BE_W-1:0]   wrBe,
  input  logic [COMP_W-1:0] wrByte,
  output clutStrobe_t       strb,
  output logic [IDX_W-1:0]  curIdx,
  output logic [1:0]        seqSt
);
  localparam logic [ADDR_W-3:0] WORD_IDX  = '0;
  localparam logic [ADDR_W-3:0] WORD_COMP = 1;

  logic accept, isIdx, isComp;

  assign accept = wrEn && (wrBe == {BE_W{1'b1}}) && (wrAddr[1:0] == 2'b00);
  assign isIdx  = accept && (wrAddr[ADDR_W-1:2] == WORD_IDX);
  assign isComp = accept && (wrAddr[ADDR_W-1:2] == WORD_COMP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx <= '0;
      seqSt  <= 2'd0;
    end else if (isIdx) begin
      curIdx <= wrByte;
      seqSt  <= 2'd0;
    end else if (isComp) begin
      case (seqSt)
        2'd0: seqSt <= 2'd1;
        2'd1: seqSt <= 2'd2;
        2'd2: begin
          seqSt  <= 2'd0;
          curIdx <= curIdx + 1'b1;
        end
        default: seqSt <= 2'd0;
      endcase
    end
  end

  always_comb begin
    strb.entry  = curIdx;
    strb.value  = wrByte;
    strb.compWe = '0;
    if (isComp) begin
      for (int c = 0; c < NCOMP; c++) begin
        strb.compWe[c] = (seqSt == 2'(c));
      end
    end
  end
endmodule

// File: rtl/clut_planes.sv
module clut_planes
  import clut_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  clutStrobe_t        strb,
  input  logic [IDX_W-1:0]   lkIdx,
  output logic [COLOR_W-1:0] lkColor
);
  for (genvar c = 0; c < NCOMP; c++) begin : g_plane
    logic [COMP_W-1:0] mem [ENTRIES];
    logic [COMP_W-1:0] outQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int e = 0; e < ENTRIES; e++) begin
          mem[e] <= (e == ENTRIES - 1) ? {COMP_W{1'b1}} : '0;
        end
        outQ <= '0;
      end else begin
        if (strb.compWe[c]) mem[strb.entry] <= strb.value;
        outQ <= mem[lkIdx];
      end
    end

    // Component 0 (red) occupies the most significant byte.
    assign lkColor[(NCOMP-1-c)*COMP_W +: COMP_W] = outQ;
  end
endmodule

// File: rtl/clut_regport.sv
module clut_regport
  import clut_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [BE_W-1:0]    wrBe,
  output logic [DATA_W-1:0]  rdData,
  input  logic [IDX_W-1:0]   lkIdx,
  output logic [COLOR_W-1:0] lkColor
);
  clutStrobe_t        strb;
  logic [IDX_W-1:0]   curIdx;
  logic [1:0]         seqSt;
  logic               unusedLow;

  assign unusedLow = ^wrData[DATA_W-COMP_W-1:0];
  assign rdData    = '0;

  clut_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrBe   (wrBe),
    .wrByte (wrData[DATA_W-1 -: COMP_W]),
    .strb   (strb),
    .curIdx (curIdx),
    .seqSt  (seqSt)
  );

  clut_planes u_planes (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .lkIdx   (lkIdx),
    .lkColor (lkColor)
  );
endmodule

// File: rtl/clut_checker.sv
module clut_checker
  import clut_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [COMP_W-1:0] wrByte,
  input logic [BE_W-1:0]   wrBe,
  input logic [NCOMP-1:0]  compWe,
  input logic [IDX_W-1:0]  curIdx,
  input logic [1:0]        seqSt
);
  logic fullBe;
  assign fullBe = (wrBe == {BE_W{1'b1}});

  assert_idx_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && fullBe && wrAddr == 4'd0) |=> (curIdx == $past(wrByte) && seqSt == 2'd0));

  assert_red_then_green_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && fullBe && wrAddr == 4'd4 && seqSt == 2'd0) |=> (seqSt == 2'd1 && $stable(curIdx)));

  assert_one_comp_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(compWe));

  assert_blue_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && fullBe && wrAddr == 4'd4 && seqSt == 2'd2)
      |=> (curIdx == $past(curIdx) + 8'd1 && seqSt == 2'd0));

  assert_partial_be_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !fullBe) |=> ($stable(curIdx) && $stable(seqSt)));

  assert_partial_be_nowrite_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !fullBe) |-> (compWe == '0));

  assert_other_offset_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != 4'd0 && wrAddr != 4'd4) |=> ($stable(curIdx) && $stable(seqSt)));
endmodule

bind clut_regport clut_checker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrAddr (wrAddr),
  .wrByte (wrData[31:24]),
  .wrBe   (wrBe),
  .compWe (strb.compWe),
  .curIdx (curIdx),
  .seqSt  (seqSt)
);

// File: tb/sim_clut_regport.sv
`timescale 1ns/1ps
module sim_clut_regport;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  wrBe = '0;
  logic [31:0] rdData;
  logic [7:0]  lkIdx = '0;
  logic [23:0] lkColor;

  always #2 clk = ~clk;

  clut_regport u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrBe(wrBe), .rdData(rdData), .lkIdx(lkIdx), .lkColor(lkColor)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Reference model built from the requirements
  logic [7:0] refR [256];
  logic [7:0] refG [256];
  logic [7:0] refB [256];
  logic [7:0] refIdx;
  int         refSeq;

  logic [23:0] expQ [$];
  string       tagQ [$];
  logic        lkReqV = 1'b0;
  logic        armed = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] refColor(input logic [7:0] e);
    return {refR[e], refG[e], refB[e]};
  endfunction

  task automatic modelWrite(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    if (be == 4'hF && a[1:0] == 2'b00) begin
      if (a == 4'd0) begin
        refIdx = d[31:24];
        refSeq = 0;
      end else if (a == 4'd4) begin
        case (refSeq)
          0: begin refR[refIdx] = d[31:24]; refSeq = 1; end
          1: begin refG[refIdx] = d[31:24]; refSeq = 2; end
          default: begin refB[refIdx] = d[31:24]; refIdx = refIdx + 8'd1; refSeq = 0; end
        endcase
      end
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] b, input logic [3:0] be = 4'hF);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = {b, 24'h5A_A55A}; wrBe = be;
    modelWrite(a, wrData, be);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic putColor(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    busWrite(4'd4, r); busWrite(4'd4, g); busWrite(4'd4, b);
  endtask

  task automatic lookup(input logic [7:0] e, input string tag);
    @(negedge clk);
    lkIdx = e; lkReqV = 1'b1;
    expQ.push_back(refColor(e)); tagQ.push_back(tag);
    @(negedge clk);
    lkReqV = 1'b0;
  endtask

  // Monitor: compares one cycle after each lookup request
  always @(posedge clk) armed <= lkReqV;
  always @(negedge clk) begin
    if (armed && expQ.size() > 0) begin
      logic [23:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(lkColor === e, t, {8'h0, lkColor}, {8'h0, e});
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      refR[i] = (i == 255) ? 8'hFF : 8'h00;
      refG[i] = (i == 255) ? 8'hFF : 8'h00;
      refB[i] = (i == 255) ? 8'hFF : 8'h00;
    end
    refIdx = 8'd0; refSeq = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset contents
    lookup(8'd0,   "R1 entry0 black");
    lookup(8'd77,  "R1 entry77 black");
    lookup(8'd255, "R1 entry255 white");
    check(rdData === 32'h0, "R10 read zero after reset", rdData, 32'h0);

    // R1/R3: no pointer write, stream lands in entry 0 as R,G,B
    putColor(8'h11, 8'h22, 8'h33);
    lookup(8'd0, "R1 R3 default pointer entry0");

    // R2/R3/R4: pointer 10, two consecutive entries
    busWrite(4'd0, 8'd10);
    putColor(8'hA1, 8'hB2, 8'hC3);
    putColor(8'h01, 8'h02, 8'h03);
    lookup(8'd10, "R2 R3 entry10");
    lookup(8'd11, "R4 increment entry11");

    // R4: wrap from 255 to 0
    busWrite(4'd0, 8'd255);
    putColor(8'h44, 8'h55, 8'h66);
    putColor(8'h77, 8'h88, 8'h99);
    lookup(8'd255, "R4 entry255 written");
    lookup(8'd0,   "R4 wrap to entry0");

    // R5: interrupted sequence then reload
    busWrite(4'd0, 8'd20);
    busWrite(4'd4, 8'hE1);
    busWrite(4'd4, 8'hE2);
    busWrite(4'd0, 8'd21);
    putColor(8'hF1, 8'hF2, 8'hF3);
    lookup(8'd20, "R5 partial bytes kept");
    lookup(8'd21, "R5 restart at red");

    // R8: partial byte enables (pointer now 22)
    busWrite(4'd0, 8'd50, 4'b0111);
    busWrite(4'd4, 8'hDE, 4'b1110);
    busWrite(4'd4, 8'hDF, 4'b0000);
    putColor(8'h31, 8'h32, 8'h33);
    lookup(8'd22, "R8 partial be ignored entry22");
    lookup(8'd50, "R8 pointer not loaded entry50");

    // R9: other offsets and unaligned (pointer now 23)
    busWrite(4'd8,  8'd90);
    busWrite(4'd12, 8'd91);
    busWrite(4'd5,  8'hBB);
    busWrite(4'd1,  8'd92);
    busWrite(4'd4, 8'h61);
    busWrite(4'd14, 8'hCC);
    busWrite(4'd4, 8'h62);
    busWrite(4'd4, 8'h63);
    lookup(8'd23, "R9 other offsets ignored entry23");
    lookup(8'd90, "R9 no pointer load entry90");
    check(rdData === 32'h0, "R10 read zero after writes", rdData, 32'h0);

    // R7: write and lookup same entry at same edge (pointer now 24)
    busWrite(4'd4, 8'h71);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'd4; wrData = 32'h7200_0000; wrBe = 4'hF;
    lkIdx = 8'd24; lkReqV = 1'b1;
    expQ.push_back(refColor(8'd24)); tagQ.push_back("R7 read before write");
    modelWrite(4'd4, wrData, 4'hF);
    @(negedge clk);
    wrEn = 1'b0; lkReqV = 1'b0;
    lookup(8'd24, "R7 new value next lookup");

    // R6: back-to-back lookups of distinct entries
    @(negedge clk);
    lkIdx = 8'd10; lkReqV = 1'b1;
    expQ.push_back(refColor(8'd10)); tagQ.push_back("R6 pipelined entry10");
    @(negedge clk);
    lkIdx = 8'd255;
    expQ.push_back(refColor(8'd255)); tagQ.push_back("R6 pipelined entry255");
    @(negedge clk);
    lkIdx = 8'd21;
    expQ.push_back(refColor(8'd21)); tagQ.push_back("R6 pipelined entry21");
    @(negedge clk);
    lkReqV = 1'b0;
    repeat (3) @(negedge clk);

    check(expQ.size() == 0, "R6 all lookups answered", expQ.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule